// File: doc/BRIEF.md
# Reconfigurable Superset Prefix Adder

A combinational N-bit adder (8 bits by default) whose carry network is a full grid of radix-2, fan-in-2 prefix cells. Each cell has its own configuration bit. When the bit is set, the cell merges its own (generate, propagate) pair with the pair from `span` positions below. When the bit is clear, the cell forwards its own pair unchanged.

A static configuration word can therefore carve a sparser prefix network out of the grid. Examples are Kogge-Stone, Brent-Kung and Han-Carlson. A faulty cell can be bypassed by choosing a topology that avoids it.

The grid has 2·log2(N)−1 levels of N cells each. The spans rise as 1, 2, …, N/2 and then fall back as N/4, …, 1. Brent-Kung needs this many levels; Kogge-Stone and Han-Carlson fit inside them. A cell whose lower input would lie below bit 0 has no lower input and is always a plain wire.

The bit-0 generate absorbs the carry-in as g0 | p0·cin. Sum bit i is pi XOR the group generate of bits i−1..0, where pi = ai XOR bi. The carry-out is the group generate of all bits.

Top module: `ssa_adder`

## Requirements
- R1: The configuration bit of the cell at level l and bit i is `nodeCfg[l*N+i]`. With the Kogge-Stone word (levels 0..log2N−1 enabled for every bit at or above the level span, later levels off; 40'h00_00F0_FCFE for N=8), `{carryOut,sumOut}` equals A+B+Cin for every operand pair.
- R2: With the Brent-Kung word (N=8: 40'h54_2080_88AA), `{carryOut,sumOut}` equals A+B+Cin.
- R3: With the Han-Carlson word (N=8: 40'h54_00A0_A8AA), `{carryOut,sumOut}` equals A+B+Cin.
- R4: With every configuration bit set, `{carryOut,sumOut}` equals A+B+Cin.
- R5: A disabled cell forwards its own pair unchanged.
  - With an all-zero word, sum bit i equals pi XOR g(i−1), where g0 includes the carry-in. `carryOut` equals g(N−1).
  - With the Kogge-Stone word and the level-2, bit-7 cell cleared, `carryOut` equals the group generate of bits 7..4 only.
- R6: Configuration bits of cells whose bit index is below their level span have no effect on `sumOut` or `carryOut`.
- R7: The carry-in reaches every bit. 8'hFF + 8'h00 + 1 gives sum 8'h00 and carry-out 1 under any of the R1–R3 words. Sum bit 0 always equals a0 XOR b0 XOR cin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | N | First operand |
| opB | input | N | Second operand |
| carryIn | input | 1 | Carry into bit 0 |
| nodeCfg | input | (2·log2N−1)·N | Per-cell combine enables, index level·N + bit |
| sumOut | output | N | Sum bits |
| carryOut | output | 1 | Carry out of bit N−1 |

## Verification
The block holds no state, so a wrong internal value shows at the ports in the same evaluation that caused it, with no latency. A wrongly wired span, a swapped upper and lower input, or a cell that merges while disabled shows as a sum bit whose carry misses or double-counts a group of lower bits. Such a flaw stays hidden unless the operands produce a carry chain across exactly that group. For that reason the Kogge-Stone word is swept over every operand pair and both carry-in values.

The sparser words are checked with random operands and directed full-length chains. Bypass is checked against an independent model of the all-zero configuration. It is also checked through a single removed cell whose only visible effect is a lost carry-out.

// File: rtl/ssa_pkg.sv
package ssa_pkg;

  typedef struct packed {
    logic gen;
    logic prop;
  } gp_t;

  // Distance between the two inputs of a cell at a given level.
  // Rising half: 1,2,..,N/2 ; falling half: N/4,..,1.
  function automatic int unsigned levelSpan(int unsigned lvl, int unsigned logW);
    if (lvl < logW) return 1 << lvl;
    return 1 << (2 * logW - 2 - lvl);
  endfunction

  // Radix-2 prefix merge of an upper and a lower group.
  function automatic gp_t mergeGp(gp_t upper, gp_t lower);
    gp_t res;
    res.gen  = upper.gen | (upper.prop & lower.gen);
    res.prop = upper.prop & lower.prop;
    return res;
  endfunction

endpackage

// File: rtl/ssa_ctrl.sv
// Turns the raw configuration word into per-cell combine strobes.
// Cells without a lower input are forced off.
module ssa_ctrl #(
  parameter int unsigned Width  = 8,
  parameter int unsigned LogW   = $clog2(Width),
  parameter int unsigned Levels = 2 * LogW - 1
) (
  input  logic [Levels*Width-1:0]      nodeCfg,
  output logic [Levels-1:0][Width-1:0] combineEn
);
  import ssa_pkg::*;

  for (genvar l = 0; l < Levels; l++) begin : g_lvl
    localparam int unsigned Span = levelSpan(l, LogW);
    for (genvar i = 0; i < Width; i++) begin : g_bit
      if (i >= Span) begin : g_live
        assign combineEn[l][i] = nodeCfg[l*Width + i];
      end else begin : g_dead
        assign combineEn[l][i] = 1'b0;
      end
    end
  end

endmodule

// File: rtl/ssa_node.sv
// One prefix cell: merges when enabled, otherwise forwards its upper pair.
module ssa_node (
  input  ssa_pkg::gp_t upper,
  input  ssa_pkg::gp_t lower,
  input  logic         mergeEn,
  output ssa_pkg::gp_t result
);
  import ssa_pkg::*;

  gp_t merged;

  always_comb begin
    merged = mergeGp(upper, lower);
    result = mergeEn ? merged : upper;
  end

endmodule

// File: rtl/ssa_datapath.sv
module ssa_datapath #(
  parameter int unsigned Width  = 8,
  parameter int unsigned LogW   = $clog2(Width),
  parameter int unsigned Levels = 2 * LogW - 1
) (
  input  logic [Width-1:0]             opA,
  input  logic [Width-1:0]             opB,
  input  logic                         carryIn,
  input  logic [Levels-1:0][Width-1:0] combineEn,
  output logic [Width-1:0]             sumOut,
  output logic                         carryOut
);
  import ssa_pkg::*;

  logic [Width-1:0] bitGen, bitProp, foldGen;
  logic [Width-1:0] finalGen, carryVec;

  // Setup stage; the carry-in is absorbed into the bit-0 generate.
  assign bitGen  = opA & opB;
  assign bitProp = opA ^ opB;
  if (Width > 1) begin : g_fold_wide
    assign foldGen = {bitGen[Width-1:1], bitGen[0] | (bitProp[0] & carryIn)};
  end else begin : g_fold_one
    assign foldGen = bitGen[0] | (bitProp[0] & carryIn);
  end

  for (genvar l = 0; l < Levels; l++) begin : g_lvl
    localparam int unsigned Span = levelSpan(l, LogW);
    gp_t stageIn  [Width];
    gp_t stageOut [Width];

    for (genvar i = 0; i < Width; i++) begin : g_in
      if (l == 0) begin : g_first
        assign stageIn[i] = '{gen: foldGen[i], prop: bitProp[i]};
      end else begin : g_next
        assign stageIn[i] = g_lvl[l-1].stageOut[i];
      end
    end

    for (genvar i = 0; i < Width; i++) begin : g_cell
      if (i >= Span) begin : g_node
        ssa_node uNode (
          .upper   (stageIn[i]),
          .lower   (stageIn[i-Span]),
          .mergeEn (combineEn[l][i]),
          .result  (stageOut[i])
        );
      end else begin : g_wire
        assign stageOut[i] = stageIn[i];
      end
    end
  end

  for (genvar i = 0; i < Width; i++) begin : g_final
    assign finalGen[i] = g_lvl[Levels-1].stageOut[i].gen;
  end

  if (Width > 1) begin : g_carry_wide
    assign carryVec = {finalGen[Width-2:0], carryIn};
  end else begin : g_carry_one
    assign carryVec = carryIn;
  end

  assign sumOut   = bitProp ^ carryVec;
  assign carryOut = finalGen[Width-1];

endmodule

// File: rtl/ssa_adder.sv
module ssa_adder #(
  parameter int unsigned Width   = 8,
  localparam int unsigned LogW   = $clog2(Width),
  localparam int unsigned Levels = 2 * LogW - 1,
  localparam int unsigned CfgBits = Levels * Width
) (
  input  logic [Width-1:0]   opA,
  input  logic [Width-1:0]   opB,
  input  logic               carryIn,
  input  logic [CfgBits-1:0] nodeCfg,
  output logic [Width-1:0]   sumOut,
  output logic               carryOut
);

  logic [Levels-1:0][Width-1:0] combineEn;

  ssa_ctrl #(.Width(Width), .LogW(LogW), .Levels(Levels)) uCtrl (
    .nodeCfg   (nodeCfg),
    .combineEn (combineEn)
  );

  ssa_datapath #(.Width(Width), .LogW(LogW), .Levels(Levels)) uPath (
    .opA       (opA),
    .opB       (opB),
    .carryIn   (carryIn),
    .combineEn (combineEn),
    .sumOut    (sumOut),
    .carryOut  (carryOut)
  );

endmodule

// File: rtl/ssa_adder_chk.sv
module ssa_adder_chk #(
  parameter int unsigned Width   = 8,
  localparam int unsigned LogW   = $clog2(Width),
  localparam int unsigned Levels = 2 * LogW - 1,
  localparam int unsigned CfgBits = Levels * Width
) (
  input logic [Width-1:0]   opA,
  input logic [Width-1:0]   opB,
  input logic               carryIn,
  input logic [CfgBits-1:0] nodeCfg,
  input logic [Width-1:0]   sumOut,
  input logic               carryOut
);
  import ssa_pkg::*;

  function automatic logic [CfgBits-1:0] ksWord();
    logic [CfgBits-1:0] w = '0;
    for (int l = 0; l < LogW; l++)
      for (int i = 0; i < Width; i++)
        if (i >= (1 << l)) w[l*Width+i] = 1'b1;
    return w;
  endfunction

  function automatic logic [CfgBits-1:0] bkWord();
    logic [CfgBits-1:0] w = '0;
    for (int l = 0; l < Levels; l++) begin
      int s = int'(levelSpan(l, LogW));
      for (int i = 0; i < Width; i++)
        if (l < LogW) begin
          if ((i + 1) % (2 * s) == 0) w[l*Width+i] = 1'b1;
        end else if (i >= s && (i + 1) % (2 * s) == s) w[l*Width+i] = 1'b1;
    end
    return w;
  endfunction

  function automatic logic [CfgBits-1:0] hcWord();
    logic [CfgBits-1:0] w = '0;
    for (int i = 0; i < Width; i++) begin
      if (i % 2 == 1) w[i] = 1'b1;
      if (i % 2 == 0 && i > 0) w[(Levels-1)*Width+i] = 1'b1;
    end
    for (int l = 1; l < LogW; l++)
      for (int i = 0; i < Width; i++)
        if (i % 2 == 1 && i >= (1 << l)) w[l*Width+i] = 1'b1;
    return w;
  endfunction

  localparam logic [CfgBits-1:0] KsWord = ksWord();
  localparam logic [CfgBits-1:0] BkWord = bkWord();
  localparam logic [CfgBits-1:0] HcWord = hcWord();

  logic [Width:0] refSum;
  assign refSum = {1'b0, opA} + {1'b0, opB} + {{Width{1'b0}}, carryIn};

  always_comb begin
    // R1
    ks_sum_chk: assert (nodeCfg != KsWord || {carryOut, sumOut} == refSum);
    // R2
    bk_sum_chk: assert (nodeCfg != BkWord || {carryOut, sumOut} == refSum);
    // R3
    hc_sum_chk: assert (nodeCfg != HcWord || {carryOut, sumOut} == refSum);
    // R4
    full_sum_chk: assert (nodeCfg != {CfgBits{1'b1}} || {carryOut, sumOut} == refSum);
    // R5
    bypass_cout_chk: assert (Width < 2 || nodeCfg != '0 || carryOut == (opA[Width-1] & opB[Width-1]));
    // R7
    lsb_sum_chk: assert (sumOut[0] == (opA[0] ^ opB[0] ^ carryIn));
  end

endmodule

bind ssa_adder ssa_adder_chk #(.Width(Width)) uChk (
  .opA      (opA),
  .opB      (opB),
  .carryIn  (carryIn),
  .nodeCfg  (nodeCfg),
  .sumOut   (sumOut),
  .carryOut (carryOut)
);

// File: tb/ssa_adder_test.sv
`timescale 1ns/1ps
module ssa_adder_test;

  localparam int W = 8;
  localparam int CB = 40;
  localparam logic [CB-1:0] KS_CFG   = 40'h00_00F0_FCFE;
  localparam logic [CB-1:0] BK_CFG   = 40'h54_2080_88AA;
  localparam logic [CB-1:0] HC_CFG   = 40'h54_00A0_A8AA;
  localparam logic [CB-1:0] KS_WIRES = 40'h01_03FF_FFFF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [W-1:0]  opA = '0, opB = '0;
  logic          carryIn = 1'b0;
  logic [CB-1:0] nodeCfg = '0;
  logic [W-1:0]  sumOut;
  logic          carryOut;

  int checkCnt = 0;
  int failCnt  = 0;
  bit done     = 1'b0;

  ssa_adder #(.Width(W)) uut (
    .opA(opA), .opB(opB), .carryIn(carryIn), .nodeCfg(nodeCfg),
    .sumOut(sumOut), .carryOut(carryOut)
  );

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic c, input logic [CB-1:0] cfg);
    opA = a; opB = b; carryIn = c; nodeCfg = cfg;
    #1;
  endtask

  task automatic check(input string tag, input logic [W-1:0] expS, input logic expC);
    checkCnt++;
    if (sumOut !== expS || carryOut !== expC) begin
      failCnt++;
      $display("FAIL %s: a=%h b=%h cin=%b got sum=%h cout=%b expected sum=%h cout=%b",
               tag, opA, opB, carryIn, sumOut, carryOut, expS, expC);
    end
  endtask

  task automatic checkAdd(input string tag);
    logic [W:0] r;
    r = {1'b0, opA} + {1'b0, opB} + {{W{1'b0}}, carryIn};
    check(tag, r[W-1:0], r[W]);
  endtask

  // Model of the all-bypassed grid: each carry sees only the bit below.
  task automatic checkBypassModel(input string tag);
    logic [W-1:0] g, p, s;
    p = opA ^ opB;
    g = opA & opB;
    g[0] = g[0] | (p[0] & carryIn);
    s[0] = p[0] ^ carryIn;
    for (int i = 1; i < W; i++) s[i] = p[i] ^ g[i-1];
    check(tag, s, g[W-1]);
  endtask

  task automatic testIdle();
    apply('0, '0, 1'b0, '0);
    check("R5 idle zeros", 8'h00, 1'b0);
  endtask

  task automatic testKsExhaustive();
    for (int c = 0; c < 2; c++)
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 256; b++) begin
          apply(a[W-1:0], b[W-1:0], c[0], KS_CFG);
          checkAdd("R1 kogge-stone exhaustive");
        end
  endtask

  task automatic testRandom(input logic [CB-1:0] cfg, input string tag, input int n);
    for (int k = 0; k < n; k++) begin
      apply($urandom, $urandom, $urandom, cfg);
      checkAdd(tag);
    end
  endtask

  task automatic testCarryChain();
    apply(8'hFF, 8'h00, 1'b1, KS_CFG);
    check("R7 chain ks", 8'h00, 1'b1);
    apply(8'hFF, 8'h00, 1'b1, BK_CFG);
    check("R7 chain bk", 8'h00, 1'b1);
    apply(8'hFF, 8'h00, 1'b1, HC_CFG);
    check("R7 chain hc", 8'h00, 1'b1);
    apply(8'h7F, 8'h00, 1'b1, HC_CFG);
    check("R7 chain hc to msb", 8'h80, 1'b0);
    apply(8'h01, 8'h00, 1'b1, BK_CFG);
    check("R7 cin into bit0", 8'h02, 1'b0);
  endtask

  task automatic testBypass();
    apply(8'h03, 8'h01, 1'b0, '0);
    check("R5 bypass short carry", 8'h00, 1'b0);
    apply(8'h01, 8'h01, 1'b0, '0);
    check("R5 bypass single carry", 8'h02, 1'b0);
    for (int k = 0; k < 500; k++) begin
      apply($urandom, $urandom, $urandom, '0);
      checkBypassModel("R5 bypass model");
    end
    apply(8'hFF, 8'h01, 1'b0, KS_CFG & ~(40'd1 << (2*W + 7)));
    check("R5 removed cell loses cout", 8'h00, 1'b0);
    apply(8'hF0, 8'h10, 1'b0, KS_CFG & ~(40'd1 << (2*W + 7)));
    check("R5 removed cell keeps upper group", 8'h00, 1'b1);
  endtask

  task automatic testWireBits();
    for (int k = 0; k < 1000; k++) begin
      apply($urandom, $urandom, $urandom, KS_WIRES);
      checkAdd("R6 wire-position bits ignored");
    end
    apply(8'h00, 8'h00, 1'b1, 40'h01_030F_0301);
    check("R6 only wire bits set", 8'h01, 1'b0);
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    testIdle();
    testKsExhaustive();
    testRandom(BK_CFG, "R2 brent-kung random", 3000);
    testRandom(HC_CFG, "R3 han-carlson random", 3000);
    testRandom({CB{1'b1}}, "R4 all cells on random", 2000);
    testCarryChain();
    testBypass();
    testWireBits();
    done = 1'b1;
    finishRun();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finishRun();
    end
  end

endmodule